// File: doc/BRIEF.md
# Bidirectional GPIO Port With Multiplexed Bus Override

This block is an eight-pin general-purpose I/O port. Three registers sit on a small memory-mapped register bus. The output value register sits at 0x1B and the direction register at 0x1A; both can be read and written. The synchronized pin snapshot sits at 0x19 and is read-only. For each pin the block produces an output value, an output enable and a weak pullup enable. It also samples the pad inputs through a two-stage synchronizer before they can be read back.

An external-memory enable input gives the pins to a multiplexed low-order address/data bus and ignores the direction register. While this mode is active, the memory interface chooses what the pins do. It drives the low address byte during its address phase, drives write data on write cycles, and releases the pins on read cycles. Every pullup is forced on in this mode. The register bus stays fully usable, so software can prepare the port setup before it takes the pins back.

Top module: `gpio_port_bus`

## Requirements
- R1: After reset the value and direction registers are 0, every pad_oe and pad_pu bit is 0, and reads of 0x1B and 0x1A return 0.
- R2: A write with reg_addr = 0x1B loads reg_wdata into the value register at that clock edge, and a read of 0x1B returns the stored value.
- R3: A write with reg_addr = 0x1A loads reg_wdata into the direction register at that clock edge, and a read of 0x1A returns the stored value.
- R4: Writes to 0x19 or to any address other than 0x1A and 0x1B change no register. A read of any address other than 0x19, 0x1A and 0x1B returns 0.
- R5: With ext_mem_en = 0, pad_oe[i] equals direction bit i (1 = output). pad_out[i] equals value bit i when the pin is an output and 0 when it is not.
- R6: With ext_mem_en = 0, pad_pu[i] is 1 exactly when direction bit i is 0 and value bit i is 1.
- R7: A read of 0x19 returns pad_in as it was sampled two rising clock edges earlier.
- R8: With ext_mem_en = 1, all pad_pu bits are 1 and the direction register has no effect on any pad output.
- R9: With ext_mem_en = 1 and ext_addr_phase = 1, all pins are driven (pad_oe = 0xFF) with ext_addr_lo. This takes priority over ext_write.
- R10: With ext_mem_en = 1, ext_addr_phase = 0 and ext_write = 1, all pins are driven with ext_wdata.
- R11: With ext_mem_en = 1, ext_addr_phase = 0 and ext_write = 0, pad_oe = 0 and pad_out = 0.
- R12: Register writes are accepted while ext_mem_en = 1. Once ext_mem_en returns to 0, the pins follow the values written.
- R13: ext_rdata equals pad_in in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 6 | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| ext_mem_en | input | 1 | Hands the pins to the multiplexed memory bus |
| ext_addr_phase | input | 1 | Memory bus is in its address phase |
| ext_write | input | 1 | Memory bus cycle is a write |
| ext_addr_lo | input | 8 | Low address byte to drive |
| ext_wdata | input | 8 | Write data to drive |
| ext_rdata | output | 8 | Raw pad levels returned to the memory bus |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Per-pin output value |
| pad_oe | output | 8 | Per-pin output enable |
| pad_pu | output | 8 | Per-pin pullup enable |

## Verification
A register write can land in the same cycle that ext_mem_en changes. The pins must then switch owner and take the newly written value or direction at the same edge. The bench forces this case in directed steps: it drops ext_mem_en while writing the direction register. It also reaches the case randomly by toggling the mode and issuing writes independently each cycle. A reference model, updated at every rising edge, predicts each pin output and each read-back value. Every observed value must match the prediction for the cycle after the edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Control bundle for one pad
  typedef struct packed {
    logic out;
    logic oe;
    logic pu;
  } pin_ctrl_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_VAL  = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_PIN  = 2'd3
  } reg_sel_e;

  // Register-controlled pin: direction 1 drives, 0 floats with optional pullup
  function automatic pin_ctrl_t local_pin(input logic val_bit, input logic dir_bit);
    pin_ctrl_t c;
    c.oe  = dir_bit;
    c.out = dir_bit & val_bit;
    c.pu  = ~dir_bit & val_bit;
    return c;
  endfunction

  // Memory-bus-controlled pin: address phase wins, then write data, else release
  function automatic pin_ctrl_t bus_pin(input logic addr_bit, input logic wdata_bit,
                                        input logic addr_phase, input logic wr);
    pin_ctrl_t c;
    c.pu = 1'b1;
    if (addr_phase) begin
      c.oe  = 1'b1;
      c.out = addr_bit;
    end else if (wr) begin
      c.oe  = 1'b1;
      c.out = wdata_bit;
    end else begin
      c.oe  = 1'b0;
      c.out = 1'b0;
    end
    return c;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

  // Edges seen since reset, saturating; gates the history check
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                warm_q <= 2'd0;
    else if (warm_q != 2'd3)   warm_q <= warm_q + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_chk2
      AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |-> (q == $past(d, 2))); // R7
    end
  endgenerate

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int          W        = 8,
  parameter int          AW       = 6,
  parameter logic [AW-1:0] ADDR_VAL = 6'h1B,
  parameter logic [AW-1:0] ADDR_DIR = 6'h1A,
  parameter logic [AW-1:0] ADDR_PIN = 6'h19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  pin_snap,
  output logic [W-1:0]  val_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  rdata
);

  function automatic reg_sel_e decode(input logic [AW-1:0] a);
    if (a == ADDR_VAL)      return SEL_VAL;
    else if (a == ADDR_DIR) return SEL_DIR;
    else if (a == ADDR_PIN) return SEL_PIN;
    else                    return SEL_NONE;
  endfunction

  reg_sel_e sel;
  logic     val_we;
  logic     dir_we;

  assign sel    = decode(addr);
  assign val_we = wr && (sel == SEL_VAL);
  assign dir_we = wr && (sel == SEL_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      dir_q <= '0;
    end else begin
      if (val_we) val_q <= wdata;
      if (dir_we) dir_q <= wdata;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_VAL: rdata = val_q;
      SEL_DIR: rdata = dir_q;
      SEL_PIN: rdata = pin_snap;
      default: rdata = '0;
    endcase
  end

  AST_VAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_VAL) |=> (val_q == $past(wdata))); // R2
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_DIR) |=> (dir_q == $past(wdata))); // R3
  AST_PIN_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr != ADDR_VAL && addr != ADDR_DIR) |=> ($stable(val_q) && $stable(dir_q))); // R4

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alt_en,
  input  logic [W-1:0] val_q,
  input  logic [W-1:0] dir_q,
  input  logic         ext_addr_phase,
  input  logic         ext_write,
  input  logic [W-1:0] ext_addr_lo,
  input  logic [W-1:0] ext_wdata,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu
);

  // Named events for the checks below
  logic bus_addr_drive;
  logic bus_data_drive;
  logic bus_release;

  assign bus_addr_drive = alt_en && ext_addr_phase;
  assign bus_data_drive = alt_en && !ext_addr_phase && ext_write;
  assign bus_release    = alt_en && !ext_addr_phase && !ext_write;

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      pin_ctrl_t loc_c;
      pin_ctrl_t bus_c;
      pin_ctrl_t sel_c;
      assign loc_c      = local_pin(val_q[i], dir_q[i]);
      assign bus_c      = bus_pin(ext_addr_lo[i], ext_wdata[i], ext_addr_phase, ext_write);
      assign sel_c      = alt_en ? bus_c : loc_c;
      assign pad_out[i] = sel_c.out;
      assign pad_oe[i]  = sel_c.oe;
      assign pad_pu[i]  = sel_c.pu;
    end
  endgenerate

  AST_LOCAL_OE_IS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !alt_en |-> (pad_oe == dir_q)); // R5
  AST_PULL_NOT_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !alt_en |-> ((pad_pu & pad_oe) == '0)); // R6
  AST_BUS_PULLS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    alt_en |-> (&pad_pu)); // R8
  AST_BUS_ADDR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_drive |-> ((&pad_oe) && pad_out == ext_addr_lo)); // R9
  AST_BUS_DATA_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_drive |-> ((&pad_oe) && pad_out == ext_wdata)); // R10
  AST_BUS_READ_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release |-> (pad_oe == '0)); // R11

endmodule

// File: rtl/gpio_port_bus.sv
module gpio_port_bus
  import gpio_port_pkg::*;
#(
  parameter int W           = 8,
  parameter int AW          = 6,
  parameter int SYNC_STAGES = 2,
  parameter logic [AW-1:0] ADDR_VAL = 6'h1B,
  parameter logic [AW-1:0] ADDR_DIR = 6'h1A,
  parameter logic [AW-1:0] ADDR_PIN = 6'h19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic          ext_mem_en,
  input  logic          ext_addr_phase,
  input  logic          ext_write,
  input  logic [W-1:0]  ext_addr_lo,
  input  logic [W-1:0]  ext_wdata,
  output logic [W-1:0]  ext_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_pu
);

  logic [W-1:0] pin_snap;
  logic [W-1:0] val_q;
  logic [W-1:0] dir_q;

  gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_snap)
  );

  gpio_regfile #(
    .W(W), .AW(AW),
    .ADDR_VAL(ADDR_VAL), .ADDR_DIR(ADDR_DIR), .ADDR_PIN(ADDR_PIN)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (reg_addr),
    .wr       (reg_wr),
    .wdata    (reg_wdata),
    .pin_snap (pin_snap),
    .val_q    (val_q),
    .dir_q    (dir_q),
    .rdata    (reg_rdata)
  );

  gpio_pad_mux #(.W(W)) u_mux (
    .clk            (clk),
    .rst_n          (rst_n),
    .alt_en         (ext_mem_en),
    .val_q          (val_q),
    .dir_q          (dir_q),
    .ext_addr_phase (ext_addr_phase),
    .ext_write      (ext_write),
    .ext_addr_lo    (ext_addr_lo),
    .ext_wdata      (ext_wdata),
    .pad_out        (pad_out),
    .pad_oe         (pad_oe),
    .pad_pu         (pad_pu)
  );

  // Memory bus reads the raw pads; its controller times its own capture
  assign ext_rdata = pad_in;

  AST_EXT_READ_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rdata == pad_in); // R13

endmodule

// File: tb/gpio_port_bus_tb.sv
`timescale 1ns/1ps
module gpio_port_bus_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] reg_addr = 6'h00;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ext_mem_en = 1'b0;
  logic       ext_addr_phase = 1'b0;
  logic       ext_write = 1'b0;
  logic [7:0] ext_addr_lo = 8'h00;
  logic [7:0] ext_wdata = 8'h00;
  logic [7:0] ext_rdata;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_out, pad_oe, pad_pu;

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic [7:0] m_val = 8'h00, m_dir = 8'h00, m_p1 = 8'h00, m_p2 = 8'h00;

  always #10 clk = ~clk;

  gpio_port_bus u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_mem_en(ext_mem_en), .ext_addr_phase(ext_addr_phase), .ext_write(ext_write),
    .ext_addr_lo(ext_addr_lo), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  function automatic logic [7:0] exp_oe();
    if (!ext_mem_en) return m_dir;
    return (ext_addr_phase || ext_write) ? 8'hFF : 8'h00;
  endfunction

  function automatic logic [7:0] exp_out();
    if (!ext_mem_en) return m_val & m_dir;
    if (ext_addr_phase) return ext_addr_lo;
    if (ext_write) return ext_wdata;
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_pu();
    return ext_mem_en ? 8'hFF : (~m_dir & m_val);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [5:0] a);
    case (a)
      6'h1B:   return m_val;
      6'h1A:   return m_dir;
      6'h19:   return m_p2;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: model follows the edge, then outputs are compared 5 ns later
  task automatic step();
    @(posedge clk);
    if (reg_wr && reg_addr == 6'h1B) m_val = reg_wdata;
    if (reg_wr && reg_addr == 6'h1A) m_dir = reg_wdata;
    m_p2 = m_p1;
    m_p1 = pad_in;
    #5;
  endtask

  task automatic check_all();
    string oe_tag;
    if (!ext_mem_en)          oe_tag = "R5";
    else if (ext_addr_phase)  oe_tag = "R9";
    else if (ext_write)       oe_tag = "R10";
    else                      oe_tag = "R11";
    chk({oe_tag, " oe"}, pad_oe, exp_oe());
    chk({oe_tag, " out"}, pad_out, exp_out());
    chk(ext_mem_en ? "R8 pu" : "R6 pu", pad_pu, exp_pu());
    case (reg_addr)
      6'h1B:   chk("R2 read value", reg_rdata, exp_rd(reg_addr));
      6'h1A:   chk("R3 read dir", reg_rdata, exp_rd(reg_addr));
      6'h19:   chk("R7 read pins", reg_rdata, exp_rd(reg_addr));
      default: chk("R4 read unmapped", reg_rdata, exp_rd(reg_addr));
    endcase
    chk("R13 ext_rdata", ext_rdata, pad_in);
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;

    // R1: reset state
    reg_addr = 6'h1B; #1;
    chk("R1 value reset", reg_rdata, 8'h00);
    reg_addr = 6'h1A; #1;
    chk("R1 dir reset", reg_rdata, 8'h00);
    chk("R1 oe reset", pad_oe, 8'h00);
    chk("R1 pu reset", pad_pu, 8'h00);

    // R2/R3/R5/R6: mixed outputs and pulled inputs
    wr_reg(6'h1B, 8'hC6); check_all();
    wr_reg(6'h1A, 8'h0F); check_all();
    chk("R5 out drive", pad_out, 8'h06);
    chk("R6 pu select", pad_pu, 8'hC0);

    // R4: write to pin register and unmapped address leave state alone
    wr_reg(6'h19, 8'hFF);
    wr_reg(6'h2C, 8'h55);
    reg_addr = 6'h1B; #1; chk("R4 value kept", reg_rdata, 8'hC6);
    reg_addr = 6'h1A; #1; chk("R4 dir kept", reg_rdata, 8'h0F);
    reg_addr = 6'h3F; #1; chk("R4 unmapped read", reg_rdata, 8'h00);

    // R7: pin snapshot appears after exactly two edges
    reg_addr = 6'h19;
    pad_in = 8'h3C; step(); step();
    pad_in = 8'hA1; step();
    chk("R7 one edge old", reg_rdata, 8'h3C);
    step();
    chk("R7 two edges new", reg_rdata, 8'hA1);

    // R8-R11: bus override, address priority over write
    ext_mem_en = 1'b1; ext_addr_lo = 8'h5A; ext_wdata = 8'h93;
    ext_addr_phase = 1'b1; ext_write = 1'b1; #1;
    chk("R9 addr priority", pad_out, 8'h5A);
    chk("R8 pu forced", pad_pu, 8'hFF);
    ext_addr_phase = 1'b0; #1;
    chk("R10 write data", pad_out, 8'h93);
    ext_write = 1'b0; #1;
    chk("R11 released", pad_oe, 8'h00);

    // R12: writes during override, then leave override while writing dir
    wr_reg(6'h1B, 8'h81);
    chk("R8 dir ignored", pad_oe, 8'h00);
    ext_mem_en = 1'b0;
    wr_reg(6'h1A, 8'hF0);
    chk("R12 oe after exit", pad_oe, 8'hF0);
    chk("R12 out after exit", pad_out, 8'h80);
    chk("R12 pu after exit", pad_pu, 8'h01);

    // Constrained random mix
    for (int n = 0; n < 600; n++) begin
      int pick;
      pick = $urandom_range(0, 5);
      case (pick)
        0, 1:    reg_addr = 6'h1B;
        2:       reg_addr = 6'h1A;
        3:       reg_addr = 6'h19;
        default: reg_addr = 6'($urandom);
      endcase
      reg_wr         = ($urandom_range(0, 2) == 0);
      reg_wdata      = 8'($urandom);
      if ($urandom_range(0, 7) == 0) ext_mem_en = ~ext_mem_en;
      ext_addr_phase = $urandom_range(0, 1) == 1;
      ext_write      = $urandom_range(0, 1) == 1;
      ext_addr_lo    = 8'($urandom);
      ext_wdata      = 8'($urandom);
      pad_in         = 8'($urandom);
      step();
      check_all();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule